// File: doc/BRIEF.md
# Board I/O Port Decoder with Boot Memory Overlay

This block decodes the low byte of an I/O port address into chip selects for the on-board peripherals: a timer, a parallel port, a terminal UART and a printer UART. It also holds two software-written latches. The first is an extended-address byte. The second is a three-bit memory-control word that decides where two on-board memory sockets appear in the 64 KB memory map.

After reset the two sockets overlay the whole memory space, including address 0, so the processor can fetch its boot code from them. Software then writes the control latch. This moves the sockets into a fixed window at the top of memory, and it can also take either socket out of the map so that external RAM can fill the space. The block also steers the external data bus buffer. It turns the output drivers off on a bus disable request. It points the buffer inward only for reads that no on-board target answers.

Top module: `board_io_decode`

## Requirements
- R1: With `io_req` high and address bits [7:4] equal to 0, the low nibble selects exactly one target: values 0–3 assert `cs_timer`, 4–7 `cs_pio`, 8–9 `cs_tuart`, 10–11 `cs_puart`. No chip select is asserted when `io_req` is low or bits [7:4] are nonzero. Address bits [15:8] have no effect on the I/O decode.
- R2: An I/O write (`io_req` and `wr` high) to port 0x0C or 0x0D loads `data_in` into the extended-address latch at the clock edge, and `ext_addr` shows the new value from the next cycle onward. Without such a write, `ext_addr` holds its value.
- R3: An I/O write to port 0x0E or 0x0F asserts `intc_load` in the same cycle. At the clock edge it loads `data_in[2:0]` into the memory-control latch: bit 0 ends the overlay, bit 1 removes socket 0 and bit 2 removes socket 1.
- R4: Reset clears `ext_addr` to 0 and clears all three memory-control bits, which leaves the overlay active with both sockets present.
- R5: While the overlay is active, a memory request at any address enables one socket. Socket 1 is enabled when the window's socket-select bit (address bit 12 − WIN_SEL) is 1, and socket 0 is enabled otherwise.
- R6: Once the overlay is cleared, a socket is enabled only for addresses inside the window. WIN_SEL values 0, 1, 2 and 3 give windows starting at E000, F000, F800 and FC00, each running up to FFFF. The same select bit picks the socket.
- R7: A socket whose disable bit is set is never enabled, in either mode.
- R8: `buf_drive_en` is low whenever `bus_out_dis` is high.
- R9: `buf_dir_in` is high exactly when `rd` is high, a request (I/O or memory) is active, and no on-board target answers. An I/O port 0x00–0x0F or an enabled socket counts as on-board. `buf_drive_en` equals `!bus_out_dis && !buf_dir_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 16 | Address bus |
| io_req | input | 1 | I/O request strobe |
| mem_req | input | 1 | Memory request strobe |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| bus_out_dis | input | 1 | External request to disable data bus drivers |
| data_in | input | 8 | Data written to latches |
| cs_timer | output | 1 | Timer select, ports 0–3 |
| cs_pio | output | 1 | Parallel port select, ports 4–7 |
| cs_tuart | output | 1 | Terminal UART select, ports 8–9 |
| cs_puart | output | 1 | Printer UART select, ports 10–11 |
| intc_load | output | 1 | Interrupt controller load strobe, write to ports 14–15 |
| ext_addr | output | 8 | Extended-address latch contents |
| mem_cs | output | 2 | Socket enables, bit n for socket n |
| buf_drive_en | output | 1 | External data bus drivers enabled |
| buf_dir_in | output | 1 | Buffer points inward toward the processor |

## Verification
The bench builds the block with WIN_SEL = 1, which gives a 4 KB window at F000 with address bit 11 choosing the socket. With this window a plain 16-bit random address hits the window about one time in sixteen. Directed accesses at F000, F800 and 0000 add the window edge and the overlay-only region. Random writes to ports 0x0E/0x0F keep switching the control latch among overlay, normal, and one- or both-socket-removed states between random memory and I/O accesses, so the disable and window rules are exercised in every combination.

// File: rtl/ioov_pkg.sv
package ioov_pkg;

    typedef struct packed {
        logic dis1;         // socket 1 removed from map
        logic dis0;         // socket 0 removed from map
        logic overlay_off;  // overlay cleared, window mapping active
    } memctl_t;

    localparam int unsigned CTL_W = 3;

endpackage

// File: rtl/io_port_decode.sv
module io_port_decode (
    input  logic       io_req,
    input  logic       wr,
    input  logic [7:0] port,
    output logic       cs_timer,
    output logic       cs_pio,
    output logic       cs_tuart,
    output logic       cs_puart,
    output logic       ld_ext,
    output logic       ld_ctl,
    output logic       io_local
);

    logic [3:0] nib;

    always_comb begin
        nib      = port[3:0];
        io_local = io_req && (port[7:4] == 4'h0);
        cs_timer = io_local && (nib[3:2] == 2'b00);
        cs_pio   = io_local && (nib[3:2] == 2'b01);
        cs_tuart = io_local && (nib[3:1] == 3'b100);
        cs_puart = io_local && (nib[3:1] == 3'b101);
        ld_ext   = io_local && wr && (nib[3:1] == 3'b110);
        ld_ctl   = io_local && wr && (nib[3:1] == 3'b111);
    end

endmodule

// File: rtl/overlay_map.sv
module overlay_map
    import ioov_pkg::*;
#(
    parameter int unsigned HI_W = 4
) (
    input  logic            mem_req,
    input  logic [HI_W-1:0] hi_addr,
    input  memctl_t         ctl,
    output logic [1:0]      mem_cs
);

    logic win_hit;
    logic [1:0] dis;

    always_comb begin
        win_hit = &hi_addr[HI_W-1:1];
        dis     = {ctl.dis1, ctl.dis0};
    end

    for (genvar s = 0; s < 2; s++) begin : g_sock
        always_comb begin
            mem_cs[s] = mem_req && !dis[s]
                      && (ctl.overlay_off ? win_hit : 1'b1)
                      && (hi_addr[0] == 1'(s));
        end
    end

endmodule

// File: rtl/bus_buf_ctrl.sv
module bus_buf_ctrl (
    input  logic rd,
    input  logic any_req,
    input  logic on_board,
    input  logic bus_out_dis,
    output logic buf_dir_in,
    output logic buf_drive_en
);

    always_comb begin
        buf_dir_in   = rd && any_req && !on_board;
        buf_drive_en = !bus_out_dis && !buf_dir_in;
    end

endmodule

// File: rtl/board_io_decode.sv
module board_io_decode
    import ioov_pkg::*;
#(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned WIN_SEL = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              io_req,
    input  logic              mem_req,
    input  logic              rd,
    input  logic              wr,
    input  logic              bus_out_dis,
    input  logic [DATA_W-1:0] data_in,
    output logic              cs_timer,
    output logic              cs_pio,
    output logic              cs_tuart,
    output logic              cs_puart,
    output logic              intc_load,
    output logic [DATA_W-1:0] ext_addr,
    output logic [1:0]        mem_cs,
    output logic              buf_drive_en,
    output logic              buf_dir_in
);

    localparam int unsigned SEL_BIT = ADDR_W - 4 - WIN_SEL;
    localparam int unsigned HI_W    = ADDR_W - SEL_BIT;

    typedef struct packed {
        logic [DATA_W-1:0] ext;
        memctl_t           ctl;
    } state_t;

    state_t state_d, state_q;
    logic   ld_ext, ld_ctl, io_local;

    logic unused_mid_addr;
    assign unused_mid_addr = &{1'b0, addr[SEL_BIT-1:8]};

    io_port_decode u_io (
        .io_req   (io_req),
        .wr       (wr),
        .port     (addr[7:0]),
        .cs_timer (cs_timer),
        .cs_pio   (cs_pio),
        .cs_tuart (cs_tuart),
        .cs_puart (cs_puart),
        .ld_ext   (ld_ext),
        .ld_ctl   (ld_ctl),
        .io_local (io_local)
    );

    overlay_map #(.HI_W(HI_W)) u_map (
        .mem_req (mem_req),
        .hi_addr (addr[ADDR_W-1:SEL_BIT]),
        .ctl     (state_q.ctl),
        .mem_cs  (mem_cs)
    );

    bus_buf_ctrl u_buf (
        .rd           (rd),
        .any_req      (io_req || mem_req),
        .on_board     (io_local || (|mem_cs)),
        .bus_out_dis  (bus_out_dis),
        .buf_dir_in   (buf_dir_in),
        .buf_drive_en (buf_drive_en)
    );

    always_comb begin
        state_d = state_q;
        if (ld_ext) state_d.ext = data_in;
        if (ld_ctl) state_d.ctl = memctl_t'(data_in[CTL_W-1:0]);
        intc_load = ld_ctl;
        ext_addr  = state_q.ext;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    // Assertions
    logic win_hit_chk;
    assign win_hit_chk = &addr[ADDR_W-1:SEL_BIT+1];

    p_io_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cs_timer, cs_pio, cs_tuart, cs_puart, ld_ext, intc_load}));

    p_io_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !io_req |-> !(cs_timer || cs_pio || cs_tuart || cs_puart || intc_load));

    p_ext_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ext |=> (ext_addr == $past(data_in)));

    p_ext_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_ext |=> $stable(ext_addr));

    p_mem_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mem_cs));

    p_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.ctl.overlay_off && !win_hit_chk) |-> (mem_cs == 2'b00));

    p_dis0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.ctl.dis0 |-> !mem_cs[0]);

    p_dis1_r7: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.ctl.dis1 |-> !mem_cs[1]);

    p_drv_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_out_dis |-> !buf_drive_en);

    p_dir_r9: assert property (@(posedge clk) disable iff (!rst_n)
        buf_dir_in |-> (rd && (mem_cs == 2'b00) && !cs_timer && !cs_pio));

endmodule

// File: tb/sim_board_io_decode.sv
module sim_board_io_decode;

    localparam int unsigned WIN = 1;
    localparam int unsigned SELB = 12 - WIN;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        io_req = 1'b0, mem_req = 1'b0, rd = 1'b0, wr = 1'b0, bus_out_dis = 1'b0;
    logic [7:0]  data_in = '0;
    logic        cs_timer, cs_pio, cs_tuart, cs_puart, intc_load;
    logic [7:0]  ext_addr;
    logic [1:0]  mem_cs;
    logic        buf_drive_en, buf_dir_in;

    int checks = 0;
    int fails  = 0;
    logic [7:0] m_ext = '0;
    logic [2:0] m_ctl = '0;

    always #2 clk = ~clk;

    board_io_decode #(.ADDR_W(16), .DATA_W(8), .WIN_SEL(WIN)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .io_req(io_req), .mem_req(mem_req),
        .rd(rd), .wr(wr), .bus_out_dis(bus_out_dis), .data_in(data_in),
        .cs_timer(cs_timer), .cs_pio(cs_pio), .cs_tuart(cs_tuart), .cs_puart(cs_puart),
        .intc_load(intc_load), .ext_addr(ext_addr), .mem_cs(mem_cs),
        .buf_drive_en(buf_drive_en), .buf_dir_in(buf_dir_in)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h addr=%h", tag, act, exp, addr);
        end
    endtask

    function automatic logic [3:0] f_io(input logic io, input logic [15:0] a);
        if (!io || a[7:4] != 4'h0) return 4'b0000;
        case (a[3:1])
            3'd0, 3'd1: return 4'b0001;
            3'd2, 3'd3: return 4'b0010;
            3'd4:       return 4'b0100;
            3'd5:       return 4'b1000;
            default:    return 4'b0000;
        endcase
    endfunction

    function automatic logic [1:0] f_mem(input logic mq, input logic [15:0] a, input logic [2:0] c);
        logic hit;
        logic [1:0] r;
        hit = (a[15:SELB+1] == '1);
        r = '0;
        if (mq && (!c[0] || hit)) r = a[SELB] ? 2'b10 : 2'b01;
        if (c[1]) r[0] = 1'b0;
        if (c[2]) r[1] = 1'b0;
        return r;
    endfunction

    task automatic step(input logic io, input logic mq, input logic r, input logic w,
                        input logic d, input logic [15:0] a, input logic [7:0] dat);
        logic [1:0] em;
        logic onb, edir;
        string mt;
        @(negedge clk);
        io_req = io; mem_req = mq; rd = r; wr = w; bus_out_dis = d; addr = a; data_in = dat;
        #1;
        chk("R1 chip selects", {cs_puart, cs_tuart, cs_pio, cs_timer}, f_io(io, a));
        chk("R3 intc_load", intc_load, io && w && a[7:1] == 7'b0000111);
        chk("R2 ext_addr", ext_addr, m_ext);
        em = f_mem(mq, a, m_ctl);
        mt = (m_ctl[2:1] != 0) ? "R7 socket disable" : (m_ctl[0] ? "R6 window" : "R5 overlay");
        chk(mt, mem_cs, em);
        onb = (io && a[7:4] == 4'h0) || (em != 0);
        edir = r && (io || mq) && !onb;
        chk("R9 buf_dir_in", buf_dir_in, edir);
        chk(d ? "R8 drive off" : "R9 drive", buf_drive_en, !d && !edir);
        @(posedge clk);
        if (io && w && a[7:1] == 7'b0000110) m_ext = dat;
        if (io && w && a[7:1] == 7'b0000111) m_ctl = dat[2:0];
    endtask

    initial begin
        int unsigned dummy;
        dummy = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        // R4: state right after reset: ext 0, overlay active
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R4 ext after reset", ext_addr, 0);
        step(0, 1, 1, 0, 0, 16'h0000, 8'h00);  // R4/R5 overlay, socket 0
        step(0, 1, 1, 0, 0, 16'h0800, 8'h00);  // R5 overlay, socket 1
        step(1, 0, 0, 1, 0, 16'hAB0C, 8'h5A);  // R2 load ext, upper byte ignored
        step(1, 0, 1, 0, 0, 16'h0010, 8'h00);  // R1 port 0x10 not local, R9 dir in
        step(1, 0, 0, 1, 0, 16'h000E, 8'h01);  // R3 clear overlay
        step(0, 1, 1, 0, 0, 16'h0000, 8'h00);  // R6 outside window
        step(0, 1, 1, 0, 0, 16'hF000, 8'h00);  // R6 window start, socket 0
        step(0, 1, 1, 0, 0, 16'hEFFF, 8'h00);  // R6 just below window
        step(0, 1, 1, 0, 0, 16'hF800, 8'h00);  // R6 socket 1
        step(1, 0, 0, 1, 1, 16'h000F, 8'h05);  // R3 remove socket 1, R8
        step(0, 1, 1, 0, 0, 16'hF800, 8'h00);  // R7 socket 1 gone
        step(0, 1, 1, 0, 0, 16'hF7FF, 8'h00);  // R7 socket 0 still present
        step(1, 0, 0, 1, 0, 16'h000D, 8'hC3);  // R2 second port
        step(1, 0, 1, 0, 0, 16'h0009, 8'h00);  // R1 tuart
        for (int i = 0; i < 3000; i++) begin
            int unsigned k;
            logic [15:0] a;
            logic w;
            k = $urandom % 5;
            a = 16'($urandom);
            if (k == 1 && ($urandom % 4) != 0) a[7:4] = 4'h0;
            if (k == 2 && ($urandom % 2) != 0) a[15:12] = 4'hF;
            w = 1'($urandom);
            step(k == 1, k == 2 || k == 3, !w && 1'($urandom), w, ($urandom % 4) == 0,
                 a, 8'($urandom));
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule